// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written by a processor into asynchronous serial frames on a single output line. A write port loads a holding buffer. On a bit-period boundary the buffer contents move into a separate shift register, so a second character can be parked while the first is still on the line. Each frame starts with a low start bit. The data bits follow, least significant first. An optional parity bit and one or two high stop bits close the frame. The serial line rests high between frames.

Timing comes from a clock enable that pulses at a fixed multiple of the bit rate. One bit lasts `TICKS_PER_BIT` enabled ticks. Static format inputs choose the character length, parity on or off, parity sense and stop-bit count. Two flags report the state of the block: one says the holding buffer is empty, and the other says the line has finished shifting. An interrupt pulse can follow either flag. A select input chooses which one.

Top module: `uart_tx_dbuf`

## Requirements
- R1: Out of reset, txd is 1, bufEmpty is 1, shiftDone is 1 and txIrq is 0.
- R2: A frame starts with one bit at 0. The data bits follow, least significant bit first. Every bit lasts TICKS_PER_BIT ticks of tickEn.
- R3: When parityEn is 1, one parity bit follows the data bits. With parityOdd=0 it equals the XOR of the data bits sent (even parity). With parityOdd=1 it is the inverse of that XOR (odd parity).
- R4: The frame ends with one stop bit at 1 when twoStop=0, and two stop bits at 1 when twoStop=1.
- R5: bufEmpty is 0 in the cycle after a write. It returns to 1 when the buffer moves into the shift register. A second write while the buffer is still full replaces the buffer contents, and only the last value is sent.
- R6: When a character waits in the buffer as a frame ends, its start bit directly follows the last stop bit, with no idle time between them. shiftDone stays 0 across the two frames.
- R7: When no character waits, shiftDone rises exactly at the end of the last stop bit. In 2-stop mode this is the end of the second stop bit.
- R8: A write while the line is idle starts the start bit at the first bit-period boundary after the write. This is between 1 clock and one bit period later. shiftDone falls in that same cycle.
- R9: txIrq is a one-cycle pulse in the cycle after the selected flag rises. The flag is bufEmpty when irqSrcSel=0 and shiftDone when irqSrcSel=1.
- R10: When charLen8=0, seven data bits are sent. Bit 7 of the written value is neither sent nor counted in parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Oversampling tick, TICKS_PER_BIT per bit |
| wrEn | input | 1 | Write strobe into the holding buffer |
| wrData | input | DATA_W | Character to send |
| charLen8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| parityEn | input | 1 | Insert a parity bit |
| parityOdd | input | 1 | 1: odd parity, 0: even parity |
| twoStop | input | 1 | 1: two stop bits, 0: one stop bit |
| irqSrcSel | input | 1 | Interrupt source: 0 buffer empty, 1 shift done |
| txd | output | 1 | Serial output, high when idle |
| bufEmpty | output | 1 | Holding buffer is free |
| shiftDone | output | 1 | Shift register has finished the frame |
| txIrq | output | 1 | Transmit interrupt pulse |

## Verification
The bench sets TICKS_PER_BIT to 4 and DATA_W to 8, and drives tickEn every second clock, so one bit takes eight clocks. The short bit period lets every format combination, back-to-back frames, a buffer overwrite and both interrupt sources run within a few thousand cycles. It also keeps the idle-start latency window narrow enough to measure exactly against its one-bit bound.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    SEL_IDLE,
    SEL_START,
    SEL_DATA,
    SEL_PARITY,
    SEL_STOP
  } lineSel_e;

  typedef struct packed {
    logic     loadShift;
    logic     shiftBit;
    lineSel_e lineSel;
  } txStrobe_t;

endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       bufFull,
  input  logic       bufEmpty,
  input  logic       charLen8,
  input  logic       parityEn,
  input  logic       twoStop,
  input  logic       irqSrcSel,
  output txStrobe_t  strobe,
  output logic       shiftDone,
  output logic       txIrq
);

  localparam int TICK_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICKS_PER_BIT - 1);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(DATA_W - 2);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2
  } frameState_e;

  frameState_e state, nextState;
  logic [TICK_W-1:0] tickCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic [IDX_W-1:0]  lastIdx;
  logic bitBoundary;
  logic frameEnd;
  logic loadNow;
  logic shiftNow;
  logic prevShiftDone;
  logic prevBufEmpty;

  // free-running bit-period divider on the oversampling tick
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (tickEn) begin
      tickCnt <= (tickCnt == LAST_TICK) ? '0 : tickCnt + 1'b1;
    end
  end

  assign bitBoundary = tickEn && (tickCnt == LAST_TICK);
  assign lastIdx     = charLen8 ? LONG_LAST : SHORT_LAST;

  always_comb begin
    nextState = state;
    frameEnd  = 1'b0;
    shiftNow  = 1'b0;
    if (bitBoundary) begin
      case (state)
        ST_IDLE:   frameEnd = 1'b1;
        ST_START:  nextState = ST_DATA;
        ST_DATA: begin
          shiftNow = 1'b1;
          if (bitIdx == lastIdx) nextState = parityEn ? ST_PARITY : ST_STOP1;
        end
        ST_PARITY: nextState = ST_STOP1;
        ST_STOP1: begin
          if (twoStop) nextState = ST_STOP2;
          else         frameEnd  = 1'b1;
        end
        ST_STOP2:  frameEnd = 1'b1;
        default:   nextState = ST_IDLE;
      endcase
      if (frameEnd) nextState = bufFull ? ST_START : ST_IDLE;
    end
    loadNow = frameEnd && bufFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitIdx    <= '0;
      shiftDone <= 1'b1;
    end else begin
      state <= nextState;
      if (loadNow)       bitIdx <= '0;
      else if (shiftNow) bitIdx <= bitIdx + 1'b1;
      if (loadNow)
        shiftDone <= 1'b0;
      else if (frameEnd && state != ST_IDLE)
        shiftDone <= 1'b1;
    end
  end

  always_comb begin
    strobe.loadShift = loadNow;
    strobe.shiftBit  = shiftNow;
    case (state)
      ST_START:           strobe.lineSel = SEL_START;
      ST_DATA:            strobe.lineSel = SEL_DATA;
      ST_PARITY:          strobe.lineSel = SEL_PARITY;
      ST_STOP1, ST_STOP2: strobe.lineSel = SEL_STOP;
      default:            strobe.lineSel = SEL_IDLE;
    endcase
  end

  // interrupt: one pulse after the selected flag rises
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevShiftDone <= 1'b1;
      prevBufEmpty  <= 1'b1;
    end else begin
      prevShiftDone <= shiftDone;
      prevBufEmpty  <= bufEmpty;
    end
  end

  assign txIrq = irqSrcSel ? (shiftDone & ~prevShiftDone)
                           : (bufEmpty & ~prevBufEmpty);

  // R2: the frame only advances on a bit-period boundary
  p_state_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !bitBoundary |=> $stable(state));

  // R6: loading and shifting never coincide
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadShift, strobe.shiftBit}));

  // R8: shiftDone is low right after a load
  p_done_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadShift |=> !shiftDone);

  // R7: shiftDone only rises out of a stop bit
  p_done_after_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftDone) |-> $past(strobe.lineSel) == SEL_STOP);

  // R9: the interrupt is a single-cycle pulse
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |=> !txIrq);

endmodule

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              charLen8,
  input  logic              parityOdd,
  input  txStrobe_t         strobe,
  output logic              txd,
  output logic              bufEmpty,
  output logic              bufFull
);

  logic [DATA_W-1:0] txBuf;
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] maskedBuf;
  logic              parityBit;

  assign maskedBuf = charLen8 ? txBuf : {1'b0, txBuf[DATA_W-2:0]};
  assign bufFull   = ~bufEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBuf     <= '0;
      bufEmpty  <= 1'b1;
      shReg     <= '0;
      parityBit <= 1'b0;
    end else begin
      if (wrEn) txBuf <= wrData;
      if (wrEn)                  bufEmpty <= 1'b0;
      else if (strobe.loadShift) bufEmpty <= 1'b1;
      if (strobe.loadShift) begin
        shReg     <= maskedBuf;
        parityBit <= (^maskedBuf) ^ parityOdd;
      end else if (strobe.shiftBit) begin
        shReg <= shReg >> 1;
      end
    end
  end

  always_comb begin
    case (strobe.lineSel)
      SEL_START:  txd = 1'b0;
      SEL_DATA:   txd = shReg[0];
      SEL_PARITY: txd = parityBit;
      default:    txd = 1'b1;
    endcase
  end

  // R5: a write always leaves the buffer full
  p_write_fills_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !bufEmpty);

  // R5: a load without a concurrent write frees the buffer
  p_load_frees_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadShift && !wrEn) |=> bufEmpty);

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              charLen8,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              twoStop,
  input  logic              irqSrcSel,
  output logic              txd,
  output logic              bufEmpty,
  output logic              shiftDone,
  output logic              txIrq
);

  txStrobe_t strobe;
  logic      bufFull;

  uart_tx_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .DATA_W       (DATA_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .bufFull  (bufFull),
    .bufEmpty (bufEmpty),
    .charLen8 (charLen8),
    .parityEn (parityEn),
    .twoStop  (twoStop),
    .irqSrcSel(irqSrcSel),
    .strobe   (strobe),
    .shiftDone(shiftDone),
    .txIrq    (txIrq)
  );

  uart_tx_datapath #(
    .DATA_W(DATA_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .charLen8 (charLen8),
    .parityOdd(parityOdd),
    .strobe   (strobe),
    .txd      (txd),
    .bufEmpty (bufEmpty),
    .bufFull  (bufFull)
  );

endmodule

// File: tb/uart_tx_dbuf_bench.sv
module uart_tx_dbuf_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TPB        = 4;
  localparam int DW         = 8;
  localparam int BIT_CLKS   = TPB * 2;

  typedef struct {
    logic [11:0] bits;
    int          n;
  } frame_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic wrEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic charLen8 = 1'b1, parityEn = 1'b0, parityOdd = 1'b0, twoStop = 1'b0, irqSrcSel = 1'b0;
  logic txd, bufEmpty, shiftDone, txIrq;

  int checks = 0;
  int errors = 0;
  int framesSeen = 0;
  int irqCount = 0;
  int doneRises = 0;
  logic lastDone = 1'b1;
  frame_t expQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_tx_dbuf #(.TICKS_PER_BIT(TPB), .DATA_W(DW)) u_uart_tx_dbuf (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrData(wrData),
    .charLen8(charLen8), .parityEn(parityEn), .parityOdd(parityOdd),
    .twoStop(twoStop), .irqSrcSel(irqSrcSel),
    .txd(txd), .bufEmpty(bufEmpty), .shiftDone(shiftDone), .txIrq(txIrq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic frame_t buildFrame(input logic [DW-1:0] d);
    frame_t f;
    int nd;
    logic par;
    nd = charLen8 ? 8 : 7;
    f.bits = '1;
    f.bits[0] = 1'b0;
    par = parityOdd;
    for (int i = 0; i < nd; i++) begin
      f.bits[1 + i] = d[i];
      par = par ^ d[i];
    end
    f.n = 1 + nd;
    if (parityEn) begin
      f.bits[f.n] = par;
      f.n++;
    end
    f.n += twoStop ? 2 : 1;
    return f;
  endfunction

  task automatic writeByte(input logic [DW-1:0] d);
    @(negedge clk);
    wrData = d;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check(!bufEmpty, "R5 buffer full after write", bufEmpty, 0);
  endtask

  task automatic sendByte(input logic [DW-1:0] d);
    expQ.push_back(buildFrame(d));
    writeByte(d);
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (!(expQ.size() == 0 && shiftDone));
    @(negedge clk);
  endtask

  // tick generator
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) tickEn = ~tickEn;
    end
  end

  // flag watchers
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (txIrq) irqCount++;
        if (shiftDone && !lastDone) doneRises++;
        lastDone = shiftDone;
      end
    end
  end

  // monitor: pops expected frames and compares the line bit by bit
  initial begin
    logic txdPrev;
    frame_t f;
    logic [11:0] got;
    txdPrev = 1'b1;
    forever begin
      @(negedge clk);
      if (rstN && txdPrev && !txd) begin
        repeat (3) @(negedge clk);
        got = '1;
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected frame", 0, 1);
        end else begin
          f = expQ.pop_front();
          for (int i = 0; i < f.n; i++) begin
            got[i] = txd;
            if (i < f.n - 1) repeat (BIT_CLKS) @(negedge clk);
          end
          framesSeen++;
          check(got == f.bits, "R2 R3 R4 frame contents", int'(got), int'(f.bits));
        end
      end
      txdPrev = txd;
    end
  end

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    int cnt;
    frame_t tmp;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(txd == 1'b1, "R1 txd idle", txd, 1);
    check(bufEmpty == 1'b1, "R1 bufEmpty", bufEmpty, 1);
    check(shiftDone == 1'b1, "R1 shiftDone", shiftDone, 1);
    check(txIrq == 1'b0, "R1 txIrq", txIrq, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R8: idle latency, 8N1
    expQ.push_back(buildFrame(8'hA5));
    @(negedge clk);
    wrData = 8'hA5;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    cnt = 1;
    while (txd) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt >= 1 && cnt <= BIT_CLKS, "R8 start latency", cnt, BIT_CLKS);
    check(!shiftDone, "R8 shiftDone falls with start", shiftDone, 0);
    // R7: shiftDone rises at end of last stop bit
    tmp = buildFrame(8'hA5);
    cnt = 0;
    while (!shiftDone) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == tmp.n * BIT_CLKS, "R7 shiftDone timing 1 stop", cnt, tmp.n * BIT_CLKS);
    check(txd == 1'b1, "R7 line high after frame", txd, 1);
    waitIdle();

    // R10 R3: 7 bits even parity, bit 7 set
    charLen8 = 1'b0; parityEn = 1'b1; parityOdd = 1'b0; twoStop = 1'b0;
    sendByte(8'hD3);
    waitIdle();

    // R3 R4: 8 bits odd parity two stops, with R7 timing in 2-stop mode
    charLen8 = 1'b1; parityEn = 1'b1; parityOdd = 1'b1; twoStop = 1'b1;
    sendByte(8'h3C);
    while (txd) @(negedge clk);
    tmp = buildFrame(8'h3C);
    cnt = 0;
    while (!shiftDone) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == tmp.n * BIT_CLKS, "R7 shiftDone timing 2 stop", cnt, tmp.n * BIT_CLKS);
    waitIdle();

    // R10 R4: 7 bits no parity two stops
    charLen8 = 1'b0; parityEn = 1'b0; twoStop = 1'b1;
    sendByte(8'h80);
    waitIdle();

    // R6: back-to-back frames, 8E1
    charLen8 = 1'b1; parityEn = 1'b1; parityOdd = 1'b0; twoStop = 1'b0;
    doneRises = 0;
    sendByte(8'h11);
    while (bufEmpty == 1'b0) @(negedge clk);
    sendByte(8'h22);
    while (bufEmpty == 1'b0) @(negedge clk);
    check(doneRises == 0, "R6 shiftDone held between frames", doneRises, 0);
    sendByte(8'h33);
    waitIdle();
    check(doneRises == 1, "R6 single shiftDone rise", doneRises, 1);

    // R5: overwrite of a waiting character
    charLen8 = 1'b1; parityEn = 1'b0; twoStop = 1'b0;
    sendByte(8'h0F);
    while (bufEmpty == 1'b0) @(negedge clk);
    writeByte(8'h55);
    expQ.push_back(buildFrame(8'h66));
    writeByte(8'h66);
    waitIdle();
    check(framesSeen == 9, "R5 overwritten byte dropped", framesSeen, 9);

    // R9: interrupt from buffer-empty
    irqSrcSel = 1'b0;
    repeat (2) @(negedge clk);
    irqCount = 0;
    sendByte(8'h5A);
    waitIdle();
    check(irqCount == 1, "R9 irq on bufEmpty", irqCount, 1);

    // R9: interrupt from shift-done
    irqSrcSel = 1'b1;
    repeat (2) @(negedge clk);
    irqCount = 0;
    sendByte(8'hC3);
    while (txd) @(negedge clk);
    check(irqCount == 0, "R9 no irq before frame end", irqCount, 0);
    waitIdle();
    check(irqCount == 1, "R9 irq on shiftDone", irqCount, 1);

    check(expQ.size() == 0, "R2 all frames seen", expQ.size(), 0);
    check(framesSeen == 11, "R2 frame count", framesSeen, 11);
    finishRun();
  end

endmodule